// File: doc/BRIEF.md
# Segment Display Controller Status Flags

This block holds the status and event flags of a segment display controller. It keeps an enable-status bit that turns on as soon as software enables the controller. After a disable, that bit stays on until the frame being shown has finished. It raises a start-of-frame event and an update-done event. Each event has its own write-one-to-clear strobe, and the two events resolve a same-cycle set and clear in opposite directions. It also carries a pending update request, mirrors the ready line of the step-up converter, and reports when a frame-control value has taken effect.

Frame timing is generated elsewhere. The frame-start and frame-end pulses arrive already synchronous to the register bus clock. The frame-control value is written on the bus clock and is used on a separate display clock. It crosses between the two clocks through a toggle request and toggle acknowledge, with two-flop synchronizers in each direction. A sync flag goes low on every write. It goes high again once the acknowledge for the latest write has returned.

The block has two outputs: a read-only status word and one combined interrupt line.

Top module: `seg_disp_status`

## Requirements
- R1: Bit 0 of `statusWord` (enable status) reads 1 in the same cycle that `enableCtl` is 1, before any clock edge; after reset it is 0.
- R2: When `enableCtl` falls, bit 0 stays 1. It drops to 0 on the first bus clock edge at which `frameEnd` is sampled high.
- R3: Bit 1 (start-of-frame) becomes 1 on the edge that samples `frameStart` while enable status is 1. A `frameStart` seen while enable status is 0 leaves it unchanged.
- R4: A `clrSofWr` pulse clears bit 1 on the next edge. When `clrSofWr` and a start-of-frame set fall on the same edge, the clear wins.
- R5: A `updReqWr` pulse sets bit 2 (update pending) on the next edge. Bit 2 clears on the edge at which update-done is set.
- R6: Bit 3 (update-done) sets on the edge that samples `frameStart` while bits 0 and 2 are both 1. A `clrUddWr` pulse clears it on the next edge. When a set and `clrUddWr` fall on the same edge, the set wins.
- R7: `irq` = (bit1 AND `sofIrqEn`) OR (bit3 AND `uddIrqEn` AND bit0 AND `busClkRun`). It is combinational from the flags and inputs.
- R8: Bit 4 (converter ready) follows `boostReady` through two bus clock flops. A change shows after the second bus clock edge.
- R9: Bit 5 (frame-control synced) is 0 on the edge after a `fcWrEn` pulse. It returns to 1 after the display-clock handshake, and by then `fcValue` holds the written data. Bits 6 and up always read 0.
- R10: During and after reset, `statusWord`, `irq` and `fcValue` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| dispClk | input | 1 | Display clock |
| rstN | input | 1 | Active-low asynchronous reset, both domains |
| enableCtl | input | 1 | Controller enable control bit |
| frameStart | input | 1 | Pulse at the start of a frame, when display data is refreshed (bus clock) |
| frameEnd | input | 1 | Pulse at the end of a frame (bus clock) |
| updReqWr | input | 1 | Software write of 1 to the update-request bit |
| clrSofWr | input | 1 | Write-one-to-clear for start-of-frame |
| clrUddWr | input | 1 | Write-one-to-clear for update-done |
| sofIrqEn | input | 1 | Start-of-frame interrupt enable |
| uddIrqEn | input | 1 | Update-done interrupt enable |
| busClkRun | input | 1 | 1 while the bus clock is running, 0 in stop mode |
| boostReady | input | 1 | Step-up converter ready (asynchronous) |
| fcWrEn | input | 1 | Frame-control register write strobe |
| fcWrData | input | FC_W | Frame-control write data |
| fcValue | output | FC_W | Frame-control value in the display clock domain |
| statusWord | output | STAT_W | Packed status word |
| irq | output | 1 | Masked interrupt |

## Verification
Enable status and `irq` are combinational, so they are sampled shortly after the input changes and before the next bus edge. The event flags, the update-pending bit and the sync-flag clear are one register deep, so each is sampled at the falling edge after the rising edge that captures the strobe. The ready mirror is checked at both falling edges that follow a change: still old after the first rising edge and new after the second. The handshake depends on the ratio of the two clocks, so the check waits a fixed window of twenty bus cycles, well past two display and three bus flop stages.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;
  localparam int ENS_POS = 0;
  localparam int SOF_POS = 1;
  localparam int UDR_POS = 2;
  localparam int UDD_POS = 3;
  localparam int RDY_POS = 4;
  localparam int FCS_POS = 5;
  localparam int USED_BITS = 6;

  typedef struct packed {
    logic activeSet;
    logic activeClr;
    logic sofSet;
    logic sofClr;
    logic uddSet;
    logic uddClr;
    logic udrSet;
    logic udrClr;
  } flagStrobes_t;
endpackage

// File: rtl/seg_disp_ctrl.sv
module seg_disp_ctrl
  import seg_disp_pkg::*;
(
  input  logic         enableCtl,
  input  logic         frameStart,
  input  logic         frameEnd,
  input  logic         updReqWr,
  input  logic         clrSofWr,
  input  logic         clrUddWr,
  input  logic         ensNow,
  input  logic         udrNow,
  output flagStrobes_t strb
);
  always_comb begin
    strb           = '0;
    strb.activeSet = enableCtl;
    strb.activeClr = !enableCtl && frameEnd;
    strb.sofSet    = frameStart && ensNow;
    strb.sofClr    = clrSofWr;
    strb.uddSet    = frameStart && ensNow && udrNow;
    strb.uddClr    = clrUddWr;
    strb.udrSet    = updReqWr;
    strb.udrClr    = strb.uddSet;
  end
endmodule

// File: rtl/seg_disp_fc_sync.sv
module seg_disp_fc_sync #(
  parameter int FC_W = 8
) (
  input  logic            busClk,
  input  logic            dispClk,
  input  logic            rstN,
  input  logic            fcWrEn,
  input  logic [FC_W-1:0] fcWrData,
  output logic [FC_W-1:0] fcValue,
  output logic            fcSynced
);
  logic [FC_W-1:0] fcHold;
  logic            reqTog;
  logic            ackMeta, ackSync, ackSyncD;
  logic            reqMeta, reqSync, reqSyncD;
  logic            ackTog;
  logic            ackEdge;
  logic            reqEdge;

  assign ackEdge = ackSync ^ ackSyncD;
  assign reqEdge = reqSync ^ reqSyncD;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      fcHold   <= '0;
      reqTog   <= 1'b0;
      ackMeta  <= 1'b0;
      ackSync  <= 1'b0;
      ackSyncD <= 1'b0;
      fcSynced <= 1'b0;
    end else begin
      ackMeta  <= ackTog;
      ackSync  <= ackMeta;
      ackSyncD <= ackSync;
      if (fcWrEn) begin
        fcHold   <= fcWrData;
        reqTog   <= ~reqTog;
        fcSynced <= 1'b0;
      end else if (ackEdge && (ackSync == reqTog)) begin
        fcSynced <= 1'b1;
      end
    end
  end

  always_ff @(posedge dispClk or negedge rstN) begin
    if (!rstN) begin
      reqMeta  <= 1'b0;
      reqSync  <= 1'b0;
      reqSyncD <= 1'b0;
      ackTog   <= 1'b0;
      fcValue  <= '0;
    end else begin
      reqMeta  <= reqTog;
      reqSync  <= reqMeta;
      reqSyncD <= reqSync;
      if (reqEdge) begin
        fcValue <= fcHold;
        ackTog  <= reqSync;
      end
    end
  end
endmodule

// File: rtl/seg_disp_datapath.sv
module seg_disp_datapath
  import seg_disp_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              busClk,
  input  logic              rstN,
  input  flagStrobes_t      strb,
  input  logic              enableCtl,
  input  logic              sofIrqEn,
  input  logic              uddIrqEn,
  input  logic              busClkRun,
  input  logic              boostReady,
  input  logic              fcSynced,
  output logic              ensNow,
  output logic              udrNow,
  output logic [STAT_W-1:0] statusWord,
  output logic              irq
);
  logic activeReg;
  logic sofFlag, uddFlag, udrFlag;
  logic rdyMeta, rdySync;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      activeReg <= 1'b0;
      sofFlag   <= 1'b0;
      uddFlag   <= 1'b0;
      udrFlag   <= 1'b0;
      rdyMeta   <= 1'b0;
      rdySync   <= 1'b0;
    end else begin
      if (strb.activeSet)      activeReg <= 1'b1;
      else if (strb.activeClr) activeReg <= 1'b0;
      // start-of-frame: clear has priority
      if (strb.sofClr)         sofFlag <= 1'b0;
      else if (strb.sofSet)    sofFlag <= 1'b1;
      // update-done: set has priority
      if (strb.uddSet)         uddFlag <= 1'b1;
      else if (strb.uddClr)    uddFlag <= 1'b0;
      if (strb.udrSet)         udrFlag <= 1'b1;
      else if (strb.udrClr)    udrFlag <= 1'b0;
      rdyMeta <= boostReady;
      rdySync <= rdyMeta;
    end
  end

  assign ensNow = enableCtl | activeReg;
  assign udrNow = udrFlag;

  always_comb begin
    statusWord          = '0;
    statusWord[ENS_POS] = ensNow;
    statusWord[SOF_POS] = sofFlag;
    statusWord[UDR_POS] = udrFlag;
    statusWord[UDD_POS] = uddFlag;
    statusWord[RDY_POS] = rdySync;
    statusWord[FCS_POS] = fcSynced;
  end

  assign irq = (sofFlag & sofIrqEn) | (uddFlag & uddIrqEn & ensNow & busClkRun);
endmodule

// File: rtl/seg_disp_status.sv
module seg_disp_status
  import seg_disp_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int FC_W   = 8
) (
  input  logic              busClk,
  input  logic              dispClk,
  input  logic              rstN,
  input  logic              enableCtl,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              updReqWr,
  input  logic              clrSofWr,
  input  logic              clrUddWr,
  input  logic              sofIrqEn,
  input  logic              uddIrqEn,
  input  logic              busClkRun,
  input  logic              boostReady,
  input  logic              fcWrEn,
  input  logic [FC_W-1:0]   fcWrData,
  output logic [FC_W-1:0]   fcValue,
  output logic [STAT_W-1:0] statusWord,
  output logic              irq
);
  flagStrobes_t strb;
  logic ensNow, udrNow, fcSynced;

  seg_disp_ctrl ctrl_i (
    .enableCtl (enableCtl),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .updReqWr  (updReqWr),
    .clrSofWr  (clrSofWr),
    .clrUddWr  (clrUddWr),
    .ensNow    (ensNow),
    .udrNow    (udrNow),
    .strb      (strb)
  );

  seg_disp_datapath #(.STAT_W(STAT_W)) dp_i (
    .busClk    (busClk),
    .rstN      (rstN),
    .strb      (strb),
    .enableCtl (enableCtl),
    .sofIrqEn  (sofIrqEn),
    .uddIrqEn  (uddIrqEn),
    .busClkRun (busClkRun),
    .boostReady(boostReady),
    .fcSynced  (fcSynced),
    .ensNow    (ensNow),
    .udrNow    (udrNow),
    .statusWord(statusWord),
    .irq       (irq)
  );

  seg_disp_fc_sync #(.FC_W(FC_W)) fc_i (
    .busClk  (busClk),
    .dispClk (dispClk),
    .rstN    (rstN),
    .fcWrEn  (fcWrEn),
    .fcWrData(fcWrData),
    .fcValue (fcValue),
    .fcSynced(fcSynced)
  );
endmodule

// File: rtl/seg_disp_status_chk.sv
module seg_disp_status_chk #(
  parameter int STAT_W = 8
) (
  input logic              busClk,
  input logic              rstN,
  input logic              enableCtl,
  input logic              frameStart,
  input logic              frameEnd,
  input logic              clrSofWr,
  input logic              sofIrqEn,
  input logic              busClkRun,
  input logic              fcWrEn,
  input logic [STAT_W-1:0] statusWord,
  input logic              irq
);
  p_ens_on_r1: assert property (@(posedge busClk) disable iff (!rstN)
    enableCtl |-> statusWord[0]);

  p_ens_linger_r2: assert property (@(posedge busClk) disable iff (!rstN)
    (statusWord[0] && !frameEnd) |=> statusWord[0]);

  p_sof_clear_wins_r4: assert property (@(posedge busClk) disable iff (!rstN)
    clrSofWr |=> !statusWord[1]);

  p_udd_set_wins_r6: assert property (@(posedge busClk) disable iff (!rstN)
    (frameStart && statusWord[0] && statusWord[2]) |=> statusWord[3]);

  p_irq_masked_r7: assert property (@(posedge busClk) disable iff (!rstN)
    (!sofIrqEn && (!statusWord[0] || !busClkRun)) |-> !irq);

  p_sync_drop_r9: assert property (@(posedge busClk) disable iff (!rstN)
    fcWrEn |=> !statusWord[5]);

  p_upper_zero_r9: assert property (@(posedge busClk) disable iff (!rstN)
    statusWord[STAT_W-1:6] == '0);
endmodule

bind seg_disp_status seg_disp_status_chk #(.STAT_W(STAT_W)) chk_i (
  .busClk    (busClk),
  .rstN      (rstN),
  .enableCtl (enableCtl),
  .frameStart(frameStart),
  .frameEnd  (frameEnd),
  .clrSofWr  (clrSofWr),
  .sofIrqEn  (sofIrqEn),
  .busClkRun (busClkRun),
  .fcWrEn    (fcWrEn),
  .statusWord(statusWord),
  .irq       (irq)
);

// File: tb/seg_disp_status_tb.sv
module seg_disp_status_tb_top;
  localparam int STAT_W = 8;
  localparam int FC_W   = 8;

  logic busClk = 1'b0;
  logic dispClk = 1'b0;
  logic rstN = 1'b0;
  logic enableCtl = 0, frameStart = 0, frameEnd = 0, updReqWr = 0;
  logic clrSofWr = 0, clrUddWr = 0, sofIrqEn = 0, uddIrqEn = 0;
  logic busClkRun = 1, boostReady = 0, fcWrEn = 0;
  logic [FC_W-1:0]   fcWrData = '0;
  logic [FC_W-1:0]   fcValue;
  logic [STAT_W-1:0] statusWord;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 busClk = ~busClk;
  always #8.5 dispClk = ~dispClk;

  seg_disp_status #(.STAT_W(STAT_W), .FC_W(FC_W)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge busClk);
  endtask

  task automatic t_reset();
    rstN = 0;
    repeat (3) step();
    chk("R10 status", statusWord, 0);
    chk("R10 irq", irq, 0);
    chk("R10 fcValue", fcValue, 0);
    rstN = 1;
    step();
    chk("R1 ens off after reset", statusWord[0], 0);
  endtask

  task automatic t_enable();
    enableCtl = 1;
    #1;
    chk("R1 ens same cycle", statusWord[0], 1);
    step();
  endtask

  task automatic t_sof();
    frameStart = 1; step(); frameStart = 0; step();
    chk("R3 sof set", statusWord[1], 1);
    clrSofWr = 1; step(); clrSofWr = 0; step();
    chk("R4 sof cleared", statusWord[1], 0);
    frameStart = 1; step(); frameStart = 0; step();
    chk("R3 sof set again", statusWord[1], 1);
    frameStart = 1; clrSofWr = 1; step(); frameStart = 0; clrSofWr = 0; step();
    chk("R4 clear wins", statusWord[1], 0);
  endtask

  task automatic t_update();
    updReqWr = 1; step(); updReqWr = 0; step();
    chk("R5 pending set", statusWord[2], 1);
    chk("R6 done not yet", statusWord[3], 0);
    frameStart = 1; step(); frameStart = 0; step();
    chk("R6 done set", statusWord[3], 1);
    chk("R5 pending cleared", statusWord[2], 0);
    clrUddWr = 1; step(); clrUddWr = 0; step();
    chk("R6 done cleared", statusWord[3], 0);
    frameStart = 1; step(); frameStart = 0; step();
    chk("R6 no set without request", statusWord[3], 0);
    updReqWr = 1; step(); updReqWr = 0; step();
    frameStart = 1; clrUddWr = 1; step(); frameStart = 0; clrUddWr = 0; step();
    chk("R6 set wins", statusWord[3], 1);
    clrSofWr = 1; step(); clrSofWr = 0; step();
  endtask

  task automatic t_irq_disable();
    uddIrqEn = 1; sofIrqEn = 0;
    #1;
    chk("R7 udd irq", irq, 1);
    busClkRun = 0; #1;
    chk("R7 stop mode masks", irq, 0);
    busClkRun = 1; #1;
    enableCtl = 0; #1;
    chk("R2 ens lingers", statusWord[0], 1);
    chk("R7 irq while lingering", irq, 1);
    repeat (3) step();
    chk("R2 ens still on", statusWord[0], 1);
    frameEnd = 1; step(); frameEnd = 0; step();
    chk("R2 ens off at frame end", statusWord[0], 0);
    chk("R7 disabled masks", irq, 0);
    chk("R6 flag kept", statusWord[3], 1);
    frameStart = 1; step(); frameStart = 0; step();
    chk("R3 no sof while disabled", statusWord[1], 0);
    clrUddWr = 1; step(); clrUddWr = 0;
    sofIrqEn = 1; enableCtl = 1; step();
    frameStart = 1; step(); frameStart = 0; step();
    chk("R7 sof irq", irq, 1);
    sofIrqEn = 0; #1;
    chk("R7 sof masked", irq, 0);
  endtask

  task automatic t_ready();
    boostReady = 1; step();
    chk("R8 ready one edge", statusWord[4], 0);
    step();
    chk("R8 ready two edges", statusWord[4], 1);
    boostReady = 0; step(); step();
    chk("R8 ready falls", statusWord[4], 0);
  endtask

  task automatic t_fc();
    fcWrData = 8'hA5; fcWrEn = 1; step(); fcWrEn = 0; step();
    chk("R9 sync dropped", statusWord[5], 0);
    repeat (20) step();
    chk("R9 sync set", statusWord[5], 1);
    chk("R9 value crossed", fcValue, 8'hA5);
    fcWrData = 8'h3C; fcWrEn = 1; step(); fcWrEn = 0; step();
    chk("R9 sync dropped again", statusWord[5], 0);
    repeat (20) step();
    chk("R9 sync set again", statusWord[5], 1);
    chk("R9 second value", fcValue, 8'h3C);
    chk("R9 upper bits", statusWord[7:6], 0);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_sof();
    t_update();
    t_irq_disable();
    t_ready();
    t_fc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge busClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule